// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a 512-word, 18-bit first-in first-out buffer. Its write side and its read side run on two clocks that are not related to each other. Words go in on the write clock and come out through a registered output on the read clock. Five active-low status flags report how full the buffer is:

- full and empty;
- almost-full and almost-empty, each based on a programmable distance from its end;
- half-full.

The two distances are stored in registers. After reset both hold 63. A load strobe reaches these registers through the ordinary data buses. With load low, a write cycle stores bits 11:0 of the input bus into the next threshold register instead of pushing a word. A read cycle with load low places the next threshold register on bits 11:0 of the output bus instead of popping.

Back-pressure rules:

- The write side may offer a word on any write-clock edge. The word is taken only while the full flag is high.
- The read side may request a word on any read-clock edge. A word is delivered only while the empty flag is high.
- A refused request has no effect, and the caller simply retries.

The write pointer and the read pointer cross between the clock domains as Gray code, through two-flop synchronizers.

Top module: `thresh_fifo`

## Requirements
- R1: While `rst_n` is low, and after it is released, both pointers are at the first location and the buffer is empty. The outputs are then `full_n`=1, `af_n`=1, `hf_n`=1, `empty_n`=0, `ae_n`=0 and `dout`=0.
- R2: With `wen_n`=0 and `ld_n`=1, `din` is stored on the rising `wclk` edge if `full_n` was 1. If `full_n` was 0, the write is dropped. `full_n` goes low once 512 words are held.
- R3: With `ren_n`=0 and `ld_n`=1, the oldest word is loaded into `dout` on the rising `rclk` edge if `empty_n` was 1. Otherwise `dout` is unchanged. With `ren_n`=1, `dout` keeps its value. Words leave in the order they were written.
- R4: With `ld_n`=0 and `wen_n`=0, `din[11:0]` is written to a threshold register on the `wclk` edge, and no word is pushed. Successive accesses alternate between the almost-empty offset (first) and the almost-full offset (second), then wrap. Reset selects the almost-empty offset.
- R5: With `ld_n`=0 and `ren_n`=0, the selected threshold appears on `dout[11:0]` on the `rclk` edge, with `dout[17:12]`=0, and no word is popped. The read side has its own selector with the same order, wrap and reset behaviour as the write side.
- R6: `ae_n` is 0 when the stored word count is at most the almost-empty offset, and 1 otherwise.
- R7: `af_n` is 0 when the free space (512 minus the count) is at most the almost-full offset, and 1 otherwise.
- R8: `hf_n` is 0 when more than 256 words are held, and 1 otherwise.
- R9: `full_n`, `af_n` and `hf_n` update on the same `wclk` edge as a write. `empty_n` and `ae_n` update on the same `rclk` edge as a read. A change made on the opposite side shows within four edges of the flag's own clock. Pointers cross as Gray code that moves one bit per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both sides |
| wen_n | input | 1 | Write strobe, active low |
| ren_n | input | 1 | Read strobe, active low |
| ld_n | input | 1 | Threshold access select, active low |
| din | input | 18 | Write data, or threshold value on bits 11:0 |
| dout | output | 18 | Registered read data, or threshold value on bits 11:0 |
| full_n | output | 1 | Low when 512 words are held (write clock) |
| empty_n | output | 1 | Low when no word is held (read clock) |
| af_n | output | 1 | Low when free space is at most the almost-full offset (write clock) |
| ae_n | output | 1 | Low when the count is at most the almost-empty offset (read clock) |
| hf_n | output | 1 | Low when more than 256 words are held (write clock) |

## Verification
A pushed word or a programmed threshold takes effect on the write edge that accepts it. A popped word or a threshold read-back is valid on `dout` from the read edge that takes it. Flags driven by the accessing side's own clock follow on that same edge. Flags that depend on the opposite side need up to four edges of their own clock to follow.

The bench drives and samples on falling edges. It decides whether a request will be honoured from the flag seen just before the edge, and compares `dout` one falling edge later. It checks cross-domain flags only after letting both clocks run five edges with no activity.

// File: rtl/thf_pkg.sv
package thf_pkg;
  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} thr_sel_e;
endpackage

// File: rtl/thf_ptr_sync.sv
module thf_ptr_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/thf_ram.sv
module thf_ram #(
  parameter int DW = 18,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/thf_wr_side.sv
module thf_wr_side
  import thf_pkg::*;
#(
  parameter int AW      = 9,
  parameter int OFF_W   = 12,
  parameter int DEF_OFF = 63
) (
  input  logic             wclk,
  input  logic             rst_n,
  input  logic             wen_n,
  input  logic             ld_n,
  input  logic [OFF_W-1:0] thr_in,
  input  logic [AW:0]      rgray_s,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [AW:0]      wgray,
  output logic [OFF_W-1:0] ae_off,
  output logic [OFF_W-1:0] af_off,
  output logic             full_n,
  output logic             af_n,
  output logic             hf_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin, wbin_nx, rbin_s, cnt;
  logic [PW:0]   cnt_nx;
  thr_sel_e      sel;
  logic          push, ld_go;

  assign rbin_s  = g2b(rgray_s);
  assign cnt     = wbin - rbin_s;
  assign push    = !wen_n && ld_n && full_n;
  assign ld_go   = !wen_n && !ld_n;
  assign wbin_nx = wbin + PW'(push);
  assign we      = push;
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      sel    <= SEL_AE;
      ae_off <= OFF_W'(DEF_OFF);
      af_off <= OFF_W'(DEF_OFF);
    end else if (ld_go) begin
      if (sel == SEL_AE) ae_off <= thr_in;
      else               af_off <= thr_in;
      sel <= (sel == SEL_AE) ? SEL_AF : SEL_AE;
    end
  end

  // flags are combinational from registered pointers, so they move on the write edge
  always_comb begin
    cnt_nx = {1'b0, cnt};
    full_n = !(cnt == PW'(DEPTH));
    af_n   = !(32'(PW'(DEPTH) - cnt) <= 32'(af_off));
    hf_n   = !(32'(cnt) > 32'(HALF));
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
    cnt_nx <= (PW+1)'(DEPTH)); // R2
  AST_FULL_DROPS: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n && !wen_n && ld_n) |=> $stable(wbin)); // R2
  AST_LOAD_NO_PUSH: assert property (@(posedge wclk) disable iff (!rst_n)
    (!ld_n) |=> $stable(wbin)); // R4
  AST_FULL_IMPLIES_AF: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> (!af_n && !hf_n)); // R7
  AST_WGRAY_ONE_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R9
endmodule

// File: rtl/thf_rd_side.sv
module thf_rd_side
  import thf_pkg::*;
#(
  parameter int DW    = 18,
  parameter int AW    = 9,
  parameter int OFF_W = 12
) (
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             ren_n,
  input  logic             ld_n,
  input  logic [AW:0]      wgray_s,
  input  logic [OFF_W-1:0] ae_off,
  input  logic [OFF_W-1:0] af_off,
  input  logic [DW-1:0]    rdata,
  output logic [AW-1:0]    raddr,
  output logic [AW:0]      rgray,
  output logic [DW-1:0]    dout,
  output logic             empty_n,
  output logic             ae_n
);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt;
  thr_sel_e      sel;
  logic          pop, ld_go;

  assign wbin_s  = g2b(wgray_s);
  assign cnt     = wbin_s - rbin;
  assign pop     = !ren_n && ld_n && empty_n;
  assign ld_go   = !ren_n && !ld_n;
  assign rbin_nx = rbin + PW'(pop);
  assign raddr   = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      sel  <= SEL_AE;
    end else if (ld_go) begin
      dout <= DW'((sel == SEL_AE) ? ae_off : af_off);
      sel  <= (sel == SEL_AE) ? SEL_AF : SEL_AE;
    end else if (pop) begin
      dout <= rdata;
    end
  end

  assign empty_n = (cnt != '0);
  assign ae_n    = !(32'(cnt) <= 32'(ae_off));

  AST_EMPTY_DROPS: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n && !ren_n && ld_n) |=> ($stable(rbin) && $stable(dout))); // R3
  AST_DOUT_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
    ren_n |=> $stable(dout)); // R3
  AST_LOAD_NO_POP: assert property (@(posedge rclk) disable iff (!rst_n)
    (!ren_n && !ld_n) |=> $stable(rbin)); // R5
  AST_EMPTY_IMPLIES_AE: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !ae_n); // R6
  AST_RGRAY_ONE_STEP: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R9
endmodule

// File: rtl/thresh_fifo.sv
module thresh_fifo #(
  parameter int DW      = 18,
  parameter int AW      = 9,
  parameter int OFF_W   = 12,
  parameter int DEF_OFF = 63
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wen_n,
  input  logic          ren_n,
  input  logic          ld_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          full_n,
  output logic          empty_n,
  output logic          af_n,
  output logic          ae_n,
  output logic          hf_n
);
  localparam int PW = AW + 1;

  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [OFF_W-1:0]  ae_off, af_off;
  logic [DW-1:0]     rdata;

  thf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(rdata)
  );

  thf_ptr_sync #(.W(PW)) u_sync_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  thf_ptr_sync #(.W(PW)) u_sync_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  thf_wr_side #(.AW(AW), .OFF_W(OFF_W), .DEF_OFF(DEF_OFF)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n), .ld_n(ld_n),
    .thr_in(din[OFF_W-1:0]), .rgray_s(rgray_s), .we(we), .waddr(waddr),
    .wgray(wgray), .ae_off(ae_off), .af_off(af_off),
    .full_n(full_n), .af_n(af_n), .hf_n(hf_n)
  );

  thf_rd_side #(.DW(DW), .AW(AW), .OFF_W(OFF_W)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .ld_n(ld_n),
    .wgray_s(wgray_s), .ae_off(ae_off), .af_off(af_off), .rdata(rdata),
    .raddr(raddr), .rgray(rgray), .dout(dout), .empty_n(empty_n), .ae_n(ae_n)
  );
endmodule

// File: tb/thresh_fifo_bench.sv
module thresh_fifo_bench;
  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wen_n = 1'b1, ren_n = 1'b1, ld_n = 1'b1;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic full_n, empty_n, af_n, ae_n, hf_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [17:0] q[$];
  int m_ae = 63, m_af = 63;

  always #2.0 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  thresh_fifo u_thresh_fifo (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .ren_n(ren_n),
    .ld_n(ld_n), .din(din), .dout(dout), .full_n(full_n), .empty_n(empty_n),
    .af_n(af_n), .ae_n(ae_n), .hf_n(hf_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected {full_n, af_n, hf_n, empty_n, ae_n}
  function automatic logic [4:0] exp_flags(input int cnt, input int ae, input int af);
    return {cnt != 512, !((512 - cnt) <= af), !(cnt > 256), cnt != 0, !(cnt <= ae)};
  endfunction

  task automatic check_flags(input string req);
    logic [4:0] e, a;
    e = exp_flags(q.size(), m_ae, m_af);
    a = {full_n, af_n, hf_n, empty_n, ae_n};
    chk(a == e, req, int'(a), int'(e));
  endtask

  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (5) @(negedge wclk);
  endtask

  task automatic wr(input logic [17:0] d);
    bit acc;
    @(negedge wclk);
    wen_n = 1'b0; din = d; acc = full_n;
    @(negedge wclk);
    wen_n = 1'b1;
    if (acc) q.push_back(d);
  endtask

  task automatic wr_n(input int n);
    for (int i = 0; i < n; i++) wr(18'($urandom));
  endtask

  task automatic rd();
    bit pop;
    logic [17:0] prev, e;
    @(negedge rclk);
    ren_n = 1'b0; pop = empty_n; prev = dout;
    @(negedge rclk);
    ren_n = 1'b1;
    if (pop) begin
      e = q.pop_front();
      chk(dout == e, "R3 order", int'(dout), int'(e));
    end else begin
      chk(dout == prev, "R3 empty hold", int'(dout), int'(prev));
    end
  endtask

  task automatic ld_wr(input int v);
    @(negedge wclk);
    ld_n = 1'b0; wen_n = 1'b0; din = 18'(v) | 18'h3f000;
    @(negedge wclk);
    ld_n = 1'b1; wen_n = 1'b1;
  endtask

  task automatic ld_rd(input int exp, input string req);
    @(negedge rclk);
    ld_n = 1'b0; ren_n = 1'b0;
    @(negedge rclk);
    ld_n = 1'b1; ren_n = 1'b1;
    chk(dout == 18'(exp), req, int'(dout), exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #40;
    chk({full_n, af_n, hf_n, empty_n, ae_n} == 5'b11100, "R1 flags in reset",
        int'({full_n, af_n, hf_n, empty_n, ae_n}), 28);
    rst_n = 1'b1;
    settle();
    check_flags("R1 flags after reset");
    chk(dout == 0, "R1 dout", int'(dout), 0);

    rd();                                    // R3 read on empty is dropped
    ld_rd(63, "R5 default ae offset");
    ld_rd(63, "R5 default af offset");
    settle();
    check_flags("R5 load read pops nothing");

    wr(18'h2a5a5);                           // R9 cross-domain empty release
    repeat (4) @(negedge rclk);
    chk(empty_n == 1'b1, "R9 empty_n release", int'(empty_n), 1);
    wr_n(62); settle(); check_flags("R6 count 63");
    wr_n(1);  settle(); check_flags("R6 count 64");
    wr_n(192); settle(); check_flags("R8 count 256");
    wr_n(1);  settle(); check_flags("R8 count 257");
    wr_n(191); settle(); check_flags("R7 count 448");
    wr_n(1);  settle(); check_flags("R7 count 449");
    wr_n(62);
    chk(full_n == 1'b1, "R2 not full at 511", int'(full_n), 1);
    wr_n(1);
    chk(full_n == 1'b0, "R9 full_n same write edge", int'(full_n), 0);
    wr_n(3);                                 // R2 writes when full are dropped
    chk(q.size() == 512, "R2 model size", q.size(), 512);
    settle(); check_flags("R2 full");
    while (q.size() > 0) rd();
    rd();
    settle(); check_flags("R3 drained");

    m_ae = 10; ld_wr(10);                    // R4 order: ae then af
    m_af = 20; ld_wr(20);
    settle(); check_flags("R4 load write pushes nothing");
    ld_rd(10, "R5 ae readback");
    ld_rd(20, "R5 af readback");
    m_ae = 30; ld_wr(30);                    // R4 selector wraps to ae
    ld_rd(30, "R4 wrap ae");
    ld_rd(20, "R4 af kept");
    wr_n(30); settle(); check_flags("R6 prog count 30");
    wr_n(1);  settle(); check_flags("R6 prog count 31");
    wr_n(460); settle(); check_flags("R7 prog count 491");
    wr_n(1);  settle(); check_flags("R7 prog count 492");
    while (q.size() > 0) rd();

    for (int i = 0; i < 600; i++) begin
      if ($urandom % 2 == 0) wr(18'($urandom));
      else rd();
      if ($urandom % 8 == 0) settle();
    end
    settle(); check_flags("R9 flags after random mix");
    while (q.size() > 0) rd();
    settle(); check_flags("R3 final drain");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule